// File: doc/BRIEF.md
# Real-Time Clock Periodic Interrupt and Flag Unit

This block is the periodic-interrupt part of a legacy PC-style real-time clock. A single counter advances on a 32.768 kHz time-base enable. A 4-bit rate code picks which counter tap raises the periodic event, and a 3-bit chain-control field runs, freezes, resets or shortens the counter. Alarm and update-ended events arrive as one-cycle input pulses from logic outside the block. Each of the three events sets a sticky flag. A summary flag and the interrupt output go high when any flag whose enable is set is pending.

The host reaches the registers through an index/data port pair on a byte-wide bus. It first writes a register number with `hostSel` low. It then reads or writes that register with `hostSel` high. Read data is combinational from the current index. A read of the flag register clears every flag at the clock edge that ends the read.

Top module: `rtc_periodic_irq`

## Requirements
- R1: A write with `hostSel`=0 loads the index. Accesses with `hostSel`=1 reach the register at that index: 0x0A control A, 0x0B config B, 0x0C flags C, 0x0D register D. Any other index reads 0x00. After reset, A reads 0x20, B 0x00, C 0x00 and D bits 6:0 read 0.
- R2: In register A, bits 3:0 hold the rate code and bits 6:4 hold the chain code. Bit 7 reads the `updateBusy` input, and writes to bit 7 are ignored.
- R3: With chain code 3'b010, rate code n from 3 to 15 sets the periodic flag every 2^(n-1) time-base ticks. Rate code 0 never sets it.
- R4: Rate codes 1 and 2 give the same periods as codes 8 and 9 (128 and 256 ticks).
- R5: Chain codes 3'b110 and 3'b111 hold the counter at zero, and no periodic event occurs. After a switch to 3'b010, the first periodic flag comes one full selected period later.
- R6: Chain codes 3'b011, 3'b100 and 3'b101 shorten the selected period by a factor of 2^5, 2^10 and 2^15, with a floor of one tick.
- R7: Chain codes 3'b000 and 3'b001 freeze the counter, and no periodic event occurs.
- R8: The counter advances only in cycles where `tickEn` is high.
- R9: Register B is read/write. Bit 4 enables the update-ended interrupt, bit 5 the alarm interrupt and bit 6 the periodic interrupt. The other bits are stored and read back unchanged.
- R10: Register C reads {irqf, pf, af, uf, 4'b0000}, with uf in bit 4, af in bit 5, pf in bit 6 and irqf in bit 7. Writes to C are ignored. Flags set whatever the state of their enables.
- R11: irqf is the OR of (pf AND B[6]), (af AND B[5]) and (uf AND B[4]). `irqOut` equals irqf.
- R12: A read of C clears uf, af and pf at the clock edge that ends the read. An event that arrives in that same cycle is still set afterwards.
- R13: In register D, bits 5:0 are read/write and bit 6 reads 0. Bit 7 reads the `battGood` input, and writes to bit 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | 32.768 kHz time-base enable, one cycle per tick |
| hostSel | input | 1 | 0 selects the index port, 1 the data port |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Read data of the currently indexed register |
| alarmPulse | input | 1 | Alarm event pulse |
| updatePulse | input | 1 | Update-ended event pulse |
| updateBusy | input | 1 | Update-in-progress status shown in A bit 7 |
| battGood | input | 1 | Battery status shown in D bit 7 |
| irqOut | output | 1 | Interrupt request, equal to the summary flag |

## Verification
Read data is combinational, so the bench samples `hostRdata` 1 ns after it drives the read strobe, before the next edge. An event pulse driven in one cycle becomes visible in C from the cycle after the next rising edge. A clearing read takes effect at the edge that ends it, so a second read issued right after it shows the cleared state.

For the period checks, the bench releases the chain from reset and then counts falling edges until `irqOut` rises. It expects exactly 2^k ticks, because the event comes at the edge where the counter's low k bits are all ones. It then gates off `tickEn` so that later reads of C see a stable value.

// File: rtl/rtc_periodic_pkg.sv
package rtc_periodic_pkg;

  localparam int unsigned RATE_W  = 4;
  localparam int unsigned CHAIN_W = 3;

  localparam logic [7:0] IDX_CTRL_A = 8'h0A;
  localparam logic [7:0] IDX_CFG_B  = 8'h0B;
  localparam logic [7:0] IDX_FLAG_C = 8'h0C;
  localparam logic [7:0] IDX_REG_D  = 8'h0D;

  localparam logic [CHAIN_W-1:0] CHAIN_RUN   = 3'b010;
  localparam logic [CHAIN_W-1:0] CHAIN_SKIP5 = 3'b011;
  localparam logic [CHAIN_W-1:0] CHAIN_SKIP10 = 3'b100;
  localparam logic [CHAIN_W-1:0] CHAIN_SKIP15 = 3'b101;

  // control-to-datapath strobes and configuration
  typedef struct packed {
    logic                clrFlags;
    logic [RATE_W-1:0]   rate;
    logic [CHAIN_W-1:0]  chain;
    logic                perEn;
    logic                almEn;
    logic                updEn;
  } rtcCtl_t;

  // flag bits in register C order, bit 7 down to bit 4
  typedef struct packed {
    logic irqf;
    logic pf;
    logic af;
    logic uf;
  } rtcFlags_t;

endpackage

// File: rtl/rtc_periodic_ctrl.sv
module rtc_periodic_ctrl
  import rtc_periodic_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostSel,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic [7:0] hostWdata,
  input  logic       updateBusy,
  input  logic       battGood,
  input  rtcFlags_t  flags,
  output logic [7:0] hostRdata,
  output rtcCtl_t    ctl
);

  logic [7:0]         idxReg;
  logic [RATE_W-1:0]  rateReg;
  logic [CHAIN_W-1:0] chainReg;
  logic [7:0]         cfgB;
  logic [5:0]         dateAlm;
  logic               dataWr;

  assign dataWr = hostWr && hostSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg   <= '0;
      rateReg  <= '0;
      chainReg <= CHAIN_RUN;
      cfgB     <= '0;
      dateAlm  <= '0;
    end else begin
      if (hostWr && !hostSel) idxReg <= hostWdata;
      if (dataWr) begin
        case (idxReg)
          IDX_CTRL_A: begin
            rateReg  <= hostWdata[3:0];
            chainReg <= hostWdata[6:4];
          end
          IDX_CFG_B: cfgB    <= hostWdata;
          IDX_REG_D: dateAlm <= hostWdata[5:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idxReg)
      IDX_CTRL_A: hostRdata = {updateBusy, chainReg, rateReg};
      IDX_CFG_B:  hostRdata = cfgB;
      IDX_FLAG_C: hostRdata = {flags, 4'b0000};
      IDX_REG_D:  hostRdata = {battGood, 1'b0, dateAlm};
      default:    hostRdata = 8'h00;
    endcase
  end

  always_comb begin
    ctl.clrFlags = hostRd && hostSel && (idxReg == IDX_FLAG_C);
    ctl.rate     = rateReg;
    ctl.chain    = chainReg;
    ctl.perEn    = cfgB[6];
    ctl.almEn    = cfgB[5];
    ctl.updEn    = cfgB[4];
  end

  AST_IDX_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !(hostWr && !hostSel) |=> $stable(idxReg)); // R1

  AST_C_NOT_STORED: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && idxReg == IDX_FLAG_C) |=> ($stable(cfgB) && $stable(rateReg) && $stable(dateAlm))); // R10

endmodule

// File: rtl/rtc_periodic_dp.sv
module rtc_periodic_dp
  import rtc_periodic_pkg::*;
#(
  parameter int unsigned DIV_W = 14
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  logic      alarmPulse,
  input  logic      updatePulse,
  input  rtcCtl_t   ctl,
  output rtcFlags_t flags,
  output logic      irqOut
);

  localparam int unsigned TAP_W = $clog2(DIV_W + 16) + 1;

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] tapMask;
  logic [TAP_W-1:0] baseTap;
  logic [TAP_W-1:0] skipBy;
  logic [TAP_W-1:0] effTap;
  logic             tapValid;
  logic             chainRst;
  logic             running;
  logic             perEvent;
  logic             pfReg, afReg, ufReg;

  // rate code to divider tap; codes 1 and 2 alias codes 8 and 9
  always_comb begin
    tapValid = 1'b1;
    case (ctl.rate)
      4'd0:    begin baseTap = '0; tapValid = 1'b0; end
      4'd1:    baseTap = TAP_W'(7);
      4'd2:    baseTap = TAP_W'(8);
      default: baseTap = TAP_W'(ctl.rate) - TAP_W'(1);
    endcase
  end

  // test bypass shortens the tap
  always_comb begin
    case (ctl.chain)
      CHAIN_SKIP5:  skipBy = TAP_W'(5);
      CHAIN_SKIP10: skipBy = TAP_W'(10);
      CHAIN_SKIP15: skipBy = TAP_W'(15);
      default:      skipBy = '0;
    endcase
    effTap = (baseTap > skipBy) ? (baseTap - skipBy) : '0;
  end

  for (genvar b = 0; b < DIV_W; b++) begin : g_mask
    assign tapMask[b] = (TAP_W'(b) < effTap);
  end

  assign chainRst = (ctl.chain[2:1] == 2'b11);
  assign running  = (ctl.chain == CHAIN_RUN) || (ctl.chain == CHAIN_SKIP5) ||
                    (ctl.chain == CHAIN_SKIP10) || (ctl.chain == CHAIN_SKIP15);
  assign perEvent = running && tickEn && tapValid && ((divCnt & tapMask) == tapMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (chainRst) begin
      divCnt <= '0;
    end else if (running && tickEn) begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  // clear first, then new events win
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pfReg <= 1'b0;
      afReg <= 1'b0;
      ufReg <= 1'b0;
    end else begin
      pfReg <= (pfReg && !ctl.clrFlags) || perEvent;
      afReg <= (afReg && !ctl.clrFlags) || alarmPulse;
      ufReg <= (ufReg && !ctl.clrFlags) || updatePulse;
    end
  end

  always_comb begin
    flags.pf   = pfReg;
    flags.af   = afReg;
    flags.uf   = ufReg;
    flags.irqf = (pfReg && ctl.perEn) || (afReg && ctl.almEn) || (ufReg && ctl.updEn);
  end

  assign irqOut = flags.irqf;

  AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !chainRst) |=> $stable(divCnt)); // R8

  AST_RESET_NO_PF: assert property (@(posedge clk) disable iff (!rstN)
    (chainRst && !pfReg) |=> !pfReg); // R5

  AST_FREEZE_NO_PF: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.chain[2:1] == 2'b00 && !pfReg) |=> !pfReg); // R7

  AST_RATE0_NO_PF: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rate == 4'd0 && !pfReg) |=> !pfReg); // R3

  AST_ALARM_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    alarmPulse |=> afReg); // R12

  AST_UPDATE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    updatePulse |=> ufReg); // R12

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clrFlags && !alarmPulse && !updatePulse && !perEvent) |=> (!pfReg && !afReg && !ufReg)); // R12

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (ctl.perEn || ctl.almEn || ctl.updEn)); // R11

endmodule

// File: rtl/rtc_periodic_irq.sv
module rtc_periodic_irq
  import rtc_periodic_pkg::*;
#(
  parameter int unsigned DIV_W = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       hostSel,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata,
  input  logic       alarmPulse,
  input  logic       updatePulse,
  input  logic       updateBusy,
  input  logic       battGood,
  output logic       irqOut
);

  rtcCtl_t   ctl;
  rtcFlags_t flags;

  rtc_periodic_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostSel    (hostSel),
    .hostWr     (hostWr),
    .hostRd     (hostRd),
    .hostWdata  (hostWdata),
    .updateBusy (updateBusy),
    .battGood   (battGood),
    .flags      (flags),
    .hostRdata  (hostRdata),
    .ctl        (ctl)
  );

  rtc_periodic_dp #(.DIV_W(DIV_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .tickEn      (tickEn),
    .alarmPulse  (alarmPulse),
    .updatePulse (updatePulse),
    .ctl         (ctl),
    .flags       (flags),
    .irqOut      (irqOut)
  );

endmodule

// File: tb/rtc_periodic_irq_tb_top.sv
module rtc_periodic_irq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;
  localparam int WATCHDOG = 150000;

  // {rate[3:0], chain[2:0], expected period in ticks[15:0]}; 0 = never
  localparam logic [22:0] VECS [NVEC] = '{
    {4'd3,  3'b010, 16'd4},
    {4'd4,  3'b010, 16'd8},
    {4'd6,  3'b010, 16'd32},
    {4'd8,  3'b010, 16'd128},
    {4'd1,  3'b010, 16'd128},
    {4'd2,  3'b010, 16'd256},
    {4'd9,  3'b010, 16'd256},
    {4'd15, 3'b010, 16'd16384},
    {4'd0,  3'b010, 16'd0},
    {4'd11, 3'b011, 16'd32},
    {4'd13, 3'b100, 16'd4},
    {4'd15, 3'b101, 16'd1},
    {4'd6,  3'b011, 16'd1},
    {4'd3,  3'b111, 16'd0},
    {4'd3,  3'b000, 16'd0},
    {4'd3,  3'b001, 16'd0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       hostSel = 1'b0;
  logic       hostWr = 1'b0;
  logic       hostRd = 1'b0;
  logic [7:0] hostWdata = 8'h00;
  logic [7:0] hostRdata;
  logic       alarmPulse = 1'b0;
  logic       updatePulse = 1'b0;
  logic       updateBusy = 1'b0;
  logic       battGood = 1'b1;
  logic       irqOut;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  logic [7:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_periodic_irq dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .hostSel(hostSel), .hostWr(hostWr),
    .hostRd(hostRd), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .alarmPulse(alarmPulse), .updatePulse(updatePulse), .updateBusy(updateBusy),
    .battGood(battGood), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic setIndex(input logic [7:0] idx);
    @(negedge clk);
    hostSel = 1'b0; hostWr = 1'b1; hostWdata = idx;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic regWrite(input logic [7:0] idx, input logic [7:0] val);
    setIndex(idx);
    hostSel = 1'b1; hostWr = 1'b1; hostWdata = val;
    @(negedge clk);
    hostWr = 1'b0; hostSel = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] idx, output logic [7:0] val);
    setIndex(idx);
    hostSel = 1'b1; hostRd = 1'b1;
    #1 val = hostRdata;
    @(negedge clk);
    hostRd = 1'b0; hostSel = 1'b0;
  endtask

  task automatic pulseEvent(input bit alarm);
    @(negedge clk);
    if (alarm) alarmPulse = 1'b1; else updatePulse = 1'b1;
    @(negedge clk);
    alarmPulse = 1'b0; updatePulse = 1'b0;
  endtask

  function automatic string vecTag(input logic [3:0] rate, input logic [2:0] chain);
    if (chain == 3'b110 || chain == 3'b111) return "R5";
    if (chain == 3'b000 || chain == 3'b001) return "R7";
    if (chain != 3'b010) return "R6";
    if (rate == 4'd1 || rate == 4'd2) return "R4";
    return "R3";
  endfunction

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        nFails++;
        nChecks++;
        $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
        $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    regRead(8'h0A, rd); check("R1 reset A", rd, 8'h20);
    regRead(8'h0B, rd); check("R1 reset B", rd, 8'h00);
    regRead(8'h0C, rd); check("R1 reset C", rd, 8'h00);
    regRead(8'h0D, rd); check("R13 reset D", rd, 8'h80);
    check("R11 reset irqOut", irqOut, 1'b0);
    regRead(8'h05, rd); check("R1 unknown index", rd, 8'h00);

    // register A bit 7
    updateBusy = 1'b1;
    regRead(8'h0A, rd); check("R2 busy shown", rd, 8'hA0);
    regWrite(8'h0A, 8'hFF);
    updateBusy = 1'b0;
    regRead(8'h0A, rd); check("R2 bit7 write ignored", rd, 8'h7F);
    regWrite(8'h0A, 8'h20);

    // register B storage
    regWrite(8'h0B, 8'h8F);
    regRead(8'h0B, rd); check("R9 B readback", rd, 8'h8F);
    check("R9 no irq without flags", irqOut, 1'b0);

    // register D
    regWrite(8'h0D, 8'hFF);
    regRead(8'h0D, rd); check("R13 D readback", rd, 8'hBF);
    battGood = 1'b0;
    regRead(8'h0D, rd); check("R13 D battery low", rd, 8'h3F);
    battGood = 1'b1;

    // register C read-only
    regWrite(8'h0C, 8'hFF);
    regRead(8'h0C, rd); check("R10 C write ignored", rd, 8'h00);
    regRead(8'h0B, rd); check("R10 C write leaves B", rd, 8'h8F);

    // alarm flag without enable
    regWrite(8'h0B, 8'h00);
    pulseEvent(1'b1);
    check("R11 masked alarm no irq", irqOut, 1'b0);
    regRead(8'h0C, rd); check("R10 alarm flag", rd, 8'h20);
    regRead(8'h0C, rd); check("R12 cleared by read", rd, 8'h00);

    // alarm flag with enable
    pulseEvent(1'b1);
    regWrite(8'h0B, 8'h20);
    check("R11 alarm irq", irqOut, 1'b1);
    regRead(8'h0C, rd); check("R11 alarm summary", rd, 8'hA0);
    check("R12 irq drops after clear", irqOut, 1'b0);

    // update-ended flag
    regWrite(8'h0B, 8'h10);
    pulseEvent(1'b0);
    check("R11 update irq", irqOut, 1'b1);
    regRead(8'h0C, rd); check("R10 update summary", rd, 8'h90);

    // event during the clearing read is kept
    pulseEvent(1'b0);
    setIndex(8'h0C);
    hostSel = 1'b1; hostRd = 1'b1; alarmPulse = 1'b1;
    #1 rd = hostRdata;
    @(negedge clk);
    hostRd = 1'b0; hostSel = 1'b0; alarmPulse = 1'b0;
    check("R12 read before collision", rd, 8'h90);
    regRead(8'h0C, rd); check("R12 colliding alarm kept", rd, 8'h20);

    // tick gating
    regWrite(8'h0B, 8'h40);
    regWrite(8'h0A, 8'h63);
    regRead(8'h0C, rd);
    regWrite(8'h0A, 8'h23);
    repeat (30) @(negedge clk);
    check("R8 no count without tick", irqOut, 1'b0);
    tickEn = 1'b1;
    begin
      int n = 0;
      while (!irqOut && n < 20) begin
        @(negedge clk);
        n++;
      end
      check("R8 period after ticks resume", 16'(n), 16'd4);
    end
    tickEn = 1'b0;

    // period table
    for (int v = 0; v < NVEC; v++) begin
      logic [3:0]  vRate;
      logic [2:0]  vChain;
      logic [15:0] vPer;
      string       tag;
      int          n;
      {vRate, vChain, vPer} = VECS[v];
      tag = vecTag(vRate, vChain);
      tickEn = 1'b1;
      regWrite(8'h0A, {1'b0, 3'b110, vRate});
      regRead(8'h0C, rd);
      check($sformatf("R5 quiet in reset, vector %0d", v), irqOut, 1'b0);
      regWrite(8'h0A, {1'b0, vChain, vRate});
      n = 0;
      if (vPer == 16'd0) begin
        repeat (200) begin
          @(negedge clk);
          if (irqOut) n++;
        end
        tickEn = 1'b0;
        check($sformatf("%s no periodic flag, vector %0d", tag, v), 16'(n), 16'd0);
      end else begin
        while (!irqOut && n < int'(vPer) + 10) begin
          @(negedge clk);
          n++;
        end
        tickEn = 1'b0;
        check($sformatf("%s period, vector %0d", tag, v), 16'(n), vPer);
        regRead(8'h0C, rd);
        check($sformatf("R10 periodic flag, vector %0d", v), rd, 8'hC0);
        regRead(8'h0C, rd);
        check($sformatf("R12 periodic cleared, vector %0d", v), rd, 8'h00);
      end
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule